// File: doc/BRIEF.md
# Prioritized Interrupt Recognition Unit

This unit sits on the processor side and decides, once per instruction boundary, whether to take an external interrupt request. The request arrives on three active-low pins that together encode a priority level. The unit compares that level with the 3-bit interrupt mask held in the status register. Levels one to six are level sensitive and must be strictly above the mask. The top level (seven) is non-maskable but edge-triggered. A held level-seven request is taken only once, and the detector re-arms only after the level drops below seven.

When a request is taken, the unit raises an acknowledge request that carries the accepted level. In the same cycle it pulses a status-register update: the new mask equals the accepted level, the supervisor bit is set and the trace bit is cleared. The acknowledge request stays high until the surrounding sequencer pulses a done input, and no new decision is made while it is pending. Saving the program counter and status word, the acknowledge bus cycle and the vector fetch are not part of this unit.

Top module: `irq_accept_unit`

## Requirements
- R1: After asynchronous reset, ack_req_o, mask_we_o, super_set_o and trace_clr_o are 0, and ack_level_o and mask_o are 0.
- R2: The request level is the bitwise inverse of ipl_ni (ipl_ni = 3'b101 is level 2). ipl_ni = 3'b111 is level 0 and is never accepted.
- R3: A decision is made only in a cycle where boundary_i is 1. With boundary_i held at 0, no request is accepted whatever the level.
- R4: A level from 1 to 6 is accepted at a boundary if and only if it is strictly greater than mask_i.
- R5: Level 7 is accepted at a boundary for every value of mask_i, including 7.
- R6: Level 7 is taken once per entry into level 7. While it is held, later boundaries do not accept it again. After the synchronized level has been below 7 and returns to 7, the request is accepted again.
- R7: One clock after the accepting boundary edge, ack_req_o rises with ack_level_o equal to the accepted level. In that same cycle only, mask_we_o, super_set_o and trace_clr_o are 1 and mask_o equals the accepted level.
- R8: ack_req_o and ack_level_o hold until done_i is sampled at 1. Boundaries and level changes while it is pending cause no new acceptance. After the done_i edge, ack_req_o is 0.
- R9: ipl_ni passes through two synchronizing flops. A level is used only after it has been the same on two synchronized samples in a row, so a level present on the pins for a single clock is never accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ipl_ni | input | 3 | Active-low encoded request level |
| mask_i | input | 3 | Current interrupt mask from the status register |
| boundary_i | input | 1 | Instruction boundary strobe |
| done_i | input | 1 | Acknowledge sequence finished; clears the pending request |
| ack_req_o | output | 1 | Interrupt taken, acknowledge pending |
| ack_level_o | output | 3 | Level being acknowledged |
| mask_we_o | output | 1 | One-cycle write strobe for the new mask |
| mask_o | output | 3 | New mask value (the accepted level) |
| super_set_o | output | 1 | One-cycle strobe to set the supervisor bit |
| trace_clr_o | output | 1 | One-cycle strobe to clear the trace bit |

## Verification
Every level from 1 to 6 is tried against every mask value from 0 to 7. This separates the strict greater-than comparison from greater-or-equal and shows that the pins are inverted. Level 7 is tried against all eight masks, which shows that the mask is bypassed. A held level 7 with repeated boundaries, followed by a drop to a masked level and a return to 7, distinguishes true edge behaviour from plain level sensitivity. Further patterns cover a level with no boundary, level changes and boundaries while a request is pending, and a one-cycle pin glitch followed by a burst of boundaries; these expose a missing boundary gate, a missing pending lock and a missing stability filter.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned LVL_W = 3;
  typedef logic [LVL_W-1:0] lvl_t;
  localparam lvl_t LVL_NONE = '0;
  localparam lvl_t LVL_TOP  = '1;
endpackage

// File: rtl/irq_level_sync.sv
module irq_level_sync #(
  parameter int unsigned LVL_W  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LVL_W-1:0] pins_ni,
  output logic [LVL_W-1:0] lvl_o
);
  logic [LVL_W-1:0] chain_q [STAGES];
  logic [LVL_W-1:0] prev_q;
  logic [LVL_W-1:0] lvl_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[s] <= '1;
        else         chain_q[s] <= pins_ni;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[s] <= '1;
        else         chain_q[s] <= chain_q[s-1];
      end
    end
  end

  // accept a level only after two equal synchronized samples
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '1;
      lvl_q  <= '0;
    end else begin
      prev_q <= chain_q[STAGES-1];
      if (prev_q == chain_q[STAGES-1]) lvl_q <= ~chain_q[STAGES-1];
    end
  end

  assign lvl_o = lvl_q;
endmodule

// File: rtl/irq_top_edge.sv
module irq_top_edge #(
  parameter int unsigned LVL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LVL_W-1:0] lvl_i,
  input  logic             taken_top_i,
  output logic             armed_o
);
  localparam logic [LVL_W-1:0] TOP = '1;
  logic armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             armed_q <= 1'b1;
    else if (lvl_i != TOP)   armed_q <= 1'b1;
    else if (taken_top_i)    armed_q <= 1'b0;
  end

  assign armed_o = armed_q;
endmodule

// File: rtl/irq_decide.sv
module irq_decide #(
  parameter int unsigned LVL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LVL_W-1:0] lvl_i,
  input  logic [LVL_W-1:0] mask_i,
  input  logic             top_armed_i,
  input  logic             boundary_i,
  input  logic             done_i,
  output logic             take_o,
  output logic             ack_req_o,
  output logic [LVL_W-1:0] ack_level_o,
  output logic             mask_we_o,
  output logic [LVL_W-1:0] mask_o,
  output logic             super_set_o,
  output logic             trace_clr_o
);
  localparam logic [LVL_W-1:0] TOP  = '1;
  localparam logic [LVL_W-1:0] NONE = '0;

  logic             pend_q;
  logic [LVL_W-1:0] lvl_q;
  logic             upd_q;
  logic             eligible;

  always_comb begin
    if (lvl_i == TOP)       eligible = top_armed_i;
    else if (lvl_i == NONE) eligible = 1'b0;
    else                    eligible = lvl_i > mask_i;
  end

  assign take_o = boundary_i && !pend_q && eligible;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      lvl_q  <= '0;
      upd_q  <= 1'b0;
    end else begin
      upd_q <= take_o;
      if (take_o) begin
        pend_q <= 1'b1;
        lvl_q  <= lvl_i;
      end else if (pend_q && done_i) begin
        pend_q <= 1'b0;
      end
    end
  end

  assign ack_req_o   = pend_q;
  assign ack_level_o = lvl_q;
  assign mask_we_o   = upd_q;
  assign mask_o      = upd_q ? lvl_q : '0;
  assign super_set_o = upd_q;
  assign trace_clr_o = upd_q;
endmodule

// File: rtl/irq_accept_unit.sv
module irq_accept_unit
  import irq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] ipl_ni,
  input  logic [2:0] mask_i,
  input  logic       boundary_i,
  input  logic       done_i,
  output logic       ack_req_o,
  output logic [2:0] ack_level_o,
  output logic       mask_we_o,
  output logic [2:0] mask_o,
  output logic       super_set_o,
  output logic       trace_clr_o
);
  lvl_t lvl;
  logic top_armed;
  logic take;

  irq_level_sync #(.LVL_W(LVL_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pins_ni (ipl_ni),
    .lvl_o   (lvl)
  );

  irq_top_edge #(.LVL_W(LVL_W)) u_edge (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lvl_i       (lvl),
    .taken_top_i (take && (lvl == LVL_TOP)),
    .armed_o     (top_armed)
  );

  irq_decide #(.LVL_W(LVL_W)) u_decide (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lvl_i       (lvl),
    .mask_i      (mask_i),
    .top_armed_i (top_armed),
    .boundary_i  (boundary_i),
    .done_i      (done_i),
    .take_o      (take),
    .ack_req_o   (ack_req_o),
    .ack_level_o (ack_level_o),
    .mask_we_o   (mask_we_o),
    .mask_o      (mask_o),
    .super_set_o (super_set_o),
    .trace_clr_o (trace_clr_o)
  );
endmodule

// File: rtl/irq_accept_checker.sv
module irq_accept_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [2:0] mask_i,
  input logic       boundary_i,
  input logic       done_i,
  input logic       ack_req_o,
  input logic [2:0] ack_level_o,
  input logic       mask_we_o,
  input logic [2:0] mask_o,
  input logic       super_set_o,
  input logic       trace_clr_o
);
  assert_hold_until_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_req_o && !done_i |=> ack_req_o);

  assert_level_stable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_req_o && !done_i |=> $stable(ack_level_o));

  assert_rise_needs_boundary_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_req_o) |-> $past(boundary_i));

  assert_mask_update_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_req_o) |-> mask_we_o && mask_o == ack_level_o);

  assert_sr_strobes_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_we_o |-> super_set_o && trace_clr_o && ack_req_o);

  assert_single_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_we_o |=> !mask_we_o);

  assert_above_mask_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_req_o) && ack_level_o != 3'd7 |-> ack_level_o > $past(mask_i));

  assert_no_level_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_req_o |-> ack_level_o != 3'd0);
endmodule

bind irq_accept_unit irq_accept_checker chk_i (.*);

// File: tb/irq_accept_unit_tb.sv
module irq_accept_unit_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] ipl_n = 3'b111;
  logic [2:0] mask = 3'd0;
  logic       bnd = 1'b0;
  logic       done = 1'b0;
  logic       ack_req;
  logic [2:0] ack_level;
  logic       mask_we;
  logic [2:0] mask_new;
  logic       sup_set;
  logic       trc_clr;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  irq_accept_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ipl_ni(ipl_n), .mask_i(mask),
    .boundary_i(bnd), .done_i(done), .ack_req_o(ack_req),
    .ack_level_o(ack_level), .mask_we_o(mask_we), .mask_o(mask_new),
    .super_set_o(sup_set), .trace_clr_o(trc_clr)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (8) @(negedge clk);
  endtask

  task automatic pulse_boundary();
    bnd = 1'b1;
    @(negedge clk);
    bnd = 1'b0;
  endtask

  task automatic finish_ack();
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
    chk(ack_req == 1'b0, "R8 cleared by done", ack_req, 0);
  endtask

  // one acceptance trial from level 0, returns to level 0
  task automatic trial(input int lvl, input int m);
    logic exp;
    exp = (lvl == 7) || (lvl != 0 && lvl > m);
    mask = 3'(m);
    ipl_n = ~3'(lvl);
    settle();
    pulse_boundary();
    chk(ack_req == exp, (lvl == 7) ? "R5 top accepted" : "R4 compare", ack_req, exp);
    if (exp) begin
      chk(ack_level == 3'(lvl), "R2 R7 ack level", ack_level, lvl);
      chk(mask_we && sup_set && trc_clr && mask_new == 3'(lvl), "R7 sr update",
          mask_new, lvl);
      @(negedge clk);
      chk(!mask_we && !sup_set && !trc_clr, "R7 one cycle", mask_we, 0);
      finish_ack();
    end else begin
      chk(!mask_we, "R4 no update", mask_we, 0);
    end
    ipl_n = 3'b111;
    settle();
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!ack_req && !mask_we && !sup_set && !trc_clr && ack_level == 0 && mask_new == 0,
        "R1 reset", ack_req, 0);
    rst_n = 1'b1;
    settle();

    // R2: level 0 never taken
    for (int m = 0; m < 8; m++) trial(0, m);

    // R4 sweep and R5 sweep
    for (int l = 1; l < 7; l++)
      for (int m = 0; m < 8; m++) trial(l, m);
    for (int m = 0; m < 8; m++) trial(7, m);

    // R3: no boundary, no acceptance
    mask = 3'd0;
    ipl_n = ~3'd6;
    repeat (12) @(negedge clk);
    chk(!ack_req, "R3 no boundary", ack_req, 0);
    ipl_n = 3'b111;
    settle();

    // R6: held top level taken once, re-armed after a dip
    mask = 3'd7;
    ipl_n = ~3'd7;
    settle();
    pulse_boundary();
    chk(ack_req, "R6 first take", ack_req, 1);
    @(negedge clk);
    finish_ack();
    for (int i = 0; i < 4; i++) begin
      pulse_boundary();
      chk(!ack_req, "R6 held not retaken", ack_req, 0);
    end
    ipl_n = ~3'd5;
    settle();
    pulse_boundary();
    chk(!ack_req, "R6 masked dip", ack_req, 0);
    ipl_n = ~3'd7;
    settle();
    pulse_boundary();
    chk(ack_req && ack_level == 3'd7, "R6 rearmed", ack_level, 7);
    @(negedge clk);
    finish_ack();
    ipl_n = 3'b111;
    settle();

    // R8: pending request locks out new decisions
    mask = 3'd0;
    ipl_n = ~3'd2;
    settle();
    pulse_boundary();
    chk(ack_req && ack_level == 3'd2, "R8 taken", ack_level, 2);
    ipl_n = ~3'd6;
    settle();
    for (int i = 0; i < 3; i++) begin
      pulse_boundary();
      chk(ack_req && ack_level == 3'd2 && !mask_we, "R8 locked", ack_level, 2);
    end
    finish_ack();
    pulse_boundary();
    chk(ack_req && ack_level == 3'd6, "R8 next decision", ack_level, 6);
    @(negedge clk);
    finish_ack();
    ipl_n = 3'b111;
    settle();

    // R9: single-cycle glitch is filtered
    ipl_n = ~3'd6;
    @(negedge clk);
    ipl_n = 3'b111;
    bnd = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk(!ack_req, "R9 glitch ignored", ack_req, 0);
    end
    bnd = 1'b0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule